// File: doc/BRIEF.md
# Page Write Collector With Column Wrap

This block sits behind a serial slave front end and gathers the data bytes of one write transfer into a page-wide buffer. The buffer goes to backing storage only when the transfer ends cleanly. A transfer targets one of two spaces. The memory array is organised in 16-byte pages. The control-register space is organised in 8-byte sections. The column pointer walks forward one step for each acknowledged byte. It wraps inside the current page, so that extra bytes replace the ones stored earlier.

When the transfer ends correctly, the block raises a one-cycle commit strobe. Alongside it, the block presents the page base address, a per-column mask of the written columns and the buffered bytes. Writes to the control-register space go through a gate. Only the status register itself may be written freely. Every other control register opens only after two earlier clean writes to the status register, the first carrying 02h and the second carrying 06h. The time-keeping section must be written as a complete 8-byte section. After each commit, a busy flag models the non-volatile write time, and all inputs are ignored while it is high.

Top module: `page_wr_buf`

## Requirements
- R1: A transfer's start address selects a 16-column array page when `tgt_ccr_i`=0 and an 8-column control section when `tgt_ccr_i`=1. The column is the low 4 or 3 address bits, and `ptr_o` shows it one cycle after `start_i`. Each `byte_i` moves `ptr_o` up by one, wrapping from the last column of the page to column 0.
- R2: Starting at array column 10 and sending 12 bytes fills columns 10..15 and then 0..5, giving mask 16'hFC3F, and leaves `ptr_o` at 6.
- R3: Bytes beyond the page size overwrite the earlier bytes of the same columns, one at a time, and the commit carries the newest value in each column.
- R4: `stop_i` after at least one byte gives a one-cycle `commit_o` in the following cycle. With it come `commit_base_o` (the address with its column bits cleared), `commit_ccr_o`, `commit_mask_o` (bit c set only for columns written in this transfer) and `commit_data_o` (column c in bits 8c+7..8c).
- R5: `stop_i` before any byte, or `abort_i` (a stop in the middle of a byte), ends the transfer with no commit and no busy period.
- R6: A control-space write that touches any column other than the status register (address 3Fh) commits only after two earlier clean status writes, 02h and then 06h. Otherwise it is dropped with no commit and no busy period. A status-only write always commits.
- R7: A control-space write to the time section (base 30h) commits only if all 8 of its columns were written. Otherwise it is dropped.
- R8: `busy_o` is high for exactly WR_CYCLES (default 20) cycles, starting in the cycle of `commit_o`. While it is high, `start_i`, `byte_i`, `stop_i` and `abort_i` have no effect.
- R9: After reset, `commit_o`=0, `busy_o`=0 and `ptr_o`=0.
- R10: A status write with any value other than the two keys closes the gate again. Any other clean transfer between the 02h write and the 06h write cancels the first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse: new write transfer, address valid |
| tgt_ccr_i | input | 1 | Target space: 1 control registers, 0 memory array |
| start_addr_i | input | ADDR_W | Start word address |
| byte_i | input | 1 | Pulse: one data byte received and acknowledged |
| byte_data_i | input | 8 | Data of that byte |
| stop_i | input | 1 | Stop seen on a byte boundary |
| abort_i | input | 1 | Stop seen in the middle of a byte |
| commit_o | output | 1 | One-cycle commit strobe |
| commit_ccr_o | output | 1 | Space of the committed page |
| commit_base_o | output | ADDR_W | Base address of the committed page |
| commit_mask_o | output | ARR_PG | Written-column mask |
| commit_data_o | output | 8*ARR_PG | Buffered bytes, column c at bits 8c+7..8c |
| ptr_o | output | $clog2(ARR_PG) | Current column pointer |
| busy_o | output | 1 | Modelled write cycle in progress |

## Verification
A scoreboard holds, for each transfer that should commit, an expected mask and set of column bytes built by a simple wrap model. The stimulus covers a mid-page start that wraps, a run longer than the page that shows overwriting, a single-column wrap at the page end, and control-section starts that wrap at 8 instead of 16. These patterns separate a correct page-size mask from a wrong one, and a correct overwrite from appending. Gating patterns try a locked write, the correct key pair, a partial time-section write, a wrapped full time-section write, a relock, and a key pair split by another transfer. Each of these patterns should end either in a scoreboard match or in no commit and no busy period at all. Transfers that end with no byte, and transfers aborted mid-byte, must leave no commit. Inputs applied during a busy period must leave the pointer unchanged.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   typedef enum logic [1:0] {
      LK_SHUT  = 2'd0,
      LK_ARMED = 2'd1,
      LK_OPEN  = 2'd2
   } lock_e;
endpackage

// File: rtl/pwb_col_ptr.sv
module pwb_col_ptr #(
   parameter int ARR_PG = 16,
   parameter int CCR_PG = 8,
   localparam int CW = $clog2(ARR_PG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          ld_ccr_i,
   input  logic [CW-1:0] col_i,
   input  logic          step_i,
   output logic [CW-1:0] col_o
);
   localparam logic [CW-1:0] AM = CW'(ARR_PG - 1);
   localparam logic [CW-1:0] CM = CW'(CCR_PG - 1);

   logic ccr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_o <= '0;
         ccr_q <= 1'b0;
      end else if (load_i) begin
         col_o <= col_i & (ld_ccr_i ? CM : AM);
         ccr_q <= ld_ccr_i;
      end else if (step_i) begin
         col_o <= (col_o + 1'b1) & (ccr_q ? CM : AM);
      end
   end

   // R1: pointer never leaves the 8-column section in control space
   p_ptr_in_sec_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ccr_q |-> (col_o <= CM));
   // R1: every accepted byte moves the pointer
   p_ptr_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (col_o != $past(col_o)));
endmodule

// File: rtl/pwb_unlock.sv
module pwb_unlock #(
   parameter logic [7:0] KEY1 = 8'h02,
   parameter logic [7:0] KEY2 = 8'h06
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       end_i,
   input  logic       stat_i,
   input  logic [7:0] val_i,
   output logic       open_o
);
   import pwb_pkg::*;

   lock_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= LK_SHUT;
      end else if (stat_i) begin
         if (val_i == KEY1)
            st_q <= LK_ARMED;
         else if (val_i == KEY2 && st_q != LK_SHUT)
            st_q <= LK_OPEN;
         else
            st_q <= LK_SHUT;
      end else if (end_i && st_q == LK_ARMED) begin
         st_q <= LK_SHUT;
      end
   end

   assign open_o = (st_q == LK_OPEN);

   // R6: the gate only opens on a status write of the second key
   p_open_on_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(open_o) |-> ($past(stat_i) && $past(val_i) == KEY2));
endmodule

// File: rtl/pwb_busy.sv
module pwb_busy #(
   parameter int WR_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   output logic busy_o
);
   generate
      if (WR_CYCLES == 0) begin : g_none
         assign busy_o = 1'b0;
      end else begin : g_cnt
         localparam int TW = $clog2(WR_CYCLES + 1);
         logic [TW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (fire_i)
               cnt_q <= TW'(WR_CYCLES);
            else if (cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end

         assign busy_o = (cnt_q != '0);

         // R8: a commit always starts a busy window
         p_busy_after_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
            fire_i |=> busy_o);
      end
   endgenerate
endmodule

// File: rtl/page_wr_buf.sv
module page_wr_buf #(
   parameter int         ADDR_W    = 8,
   parameter int         ARR_PG    = 16,
   parameter int         CCR_PG    = 8,
   parameter int         WR_CYCLES = 20,
   parameter logic [7:0] STAT_ADDR = 8'h3F,
   parameter logic [7:0] RTC_BASE  = 8'h30,
   parameter logic [7:0] KEY1      = 8'h02,
   parameter logic [7:0] KEY2      = 8'h06,
   localparam int        CW        = $clog2(ARR_PG)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                tgt_ccr_i,
   input  logic [ADDR_W-1:0]   start_addr_i,
   input  logic                byte_i,
   input  logic [7:0]          byte_data_i,
   input  logic                stop_i,
   input  logic                abort_i,
   output logic                commit_o,
   output logic                commit_ccr_o,
   output logic [ADDR_W-1:0]   commit_base_o,
   output logic [ARR_PG-1:0]   commit_mask_o,
   output logic [8*ARR_PG-1:0] commit_data_o,
   output logic [CW-1:0]       ptr_o,
   output logic                busy_o
);
   localparam logic [ADDR_W-1:0] AOFF      = ADDR_W'(ARR_PG - 1);
   localparam logic [ADDR_W-1:0] COFF      = ADDR_W'(CCR_PG - 1);
   localparam logic [ADDR_W-1:0] STAT_BASE = ADDR_W'(STAT_ADDR) & ~COFF;
   localparam logic [ADDR_W-1:0] RTC_B     = ADDR_W'(RTC_BASE);
   localparam int                STAT_COL  = int'(STAT_ADDR) % CCR_PG;
   localparam logic [ARR_PG-1:0] STAT_ONE  = ARR_PG'(1) << STAT_COL;

   generate
      if (ARR_PG < 2 || (ARR_PG & (ARR_PG - 1)) != 0) begin : g_bad_arr
         $error("ARR_PG must be a power of two, at least 2");
      end
      if (CCR_PG < 2 || (CCR_PG & (CCR_PG - 1)) != 0 || CCR_PG > ARR_PG) begin : g_bad_ccr
         $error("CCR_PG must be a power of two between 2 and ARR_PG");
      end
      if (ADDR_W < CW || ADDR_W > 8) begin : g_bad_aw
         $error("ADDR_W must cover one page and fit in 8 bits");
      end
      if ((int'(RTC_BASE) % CCR_PG) != 0) begin : g_bad_rtc
         $error("RTC_BASE must be section aligned");
      end
   endgenerate

   logic              busy, act_q, ccr_q, got_q, lk_open;
   logic [ADDR_W-1:0] base_q;
   logic [ARR_PG-1:0] mask_q;
   logic [CW-1:0]     col;

   wire take_start = !busy && start_i;
   wire live       = !busy && act_q && !start_i;
   wire ending     = live && (stop_i || abort_i);
   wire step       = live && byte_i && !stop_i && !abort_i;
   wire clean_end  = live && stop_i && !abort_i && got_q;

   // gating decision on the buffered transfer
   wire       in_stat    = ccr_q && (base_q == STAT_BASE);
   wire       others     = in_stat ? |(mask_q & ~STAT_ONE) : |mask_q;
   wire       rtc_part   = ccr_q && (base_q == RTC_B) && (mask_q[CCR_PG-1:0] != '1);
   wire       allow      = !ccr_q || ((!others || lk_open) && !rtc_part);
   wire       fire       = clean_end && allow;
   wire       stat_write = fire && in_stat && mask_q[STAT_COL];
   wire [7:0] stat_val   = commit_data_o[8*STAT_COL +: 8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         ccr_q  <= 1'b0;
         got_q  <= 1'b0;
         base_q <= '0;
         mask_q <= '0;
      end else if (take_start) begin
         act_q  <= 1'b1;
         ccr_q  <= tgt_ccr_i;
         got_q  <= 1'b0;
         base_q <= start_addr_i & ~(tgt_ccr_i ? COFF : AOFF);
         mask_q <= '0;
      end else if (ending) begin
         act_q  <= 1'b0;
      end else if (step) begin
         mask_q[col] <= 1'b1;
         got_q       <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) commit_o <= 1'b0;
      else        commit_o <= fire;
   end

   generate
      for (genvar c = 0; c < ARR_PG; c++) begin : g_lane
         logic [7:0] byte_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               byte_q <= '0;
            else if (step && col == CW'(c))
               byte_q <= byte_data_i;
         end
         assign commit_data_o[8*c +: 8] = byte_q;
      end
   endgenerate

   pwb_col_ptr #(.ARR_PG(ARR_PG), .CCR_PG(CCR_PG)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (take_start),
      .ld_ccr_i(tgt_ccr_i),
      .col_i   (start_addr_i[CW-1:0]),
      .step_i  (step),
      .col_o   (col)
   );

   pwb_unlock #(.KEY1(KEY1), .KEY2(KEY2)) u_lock (
      .clk   (clk),
      .rst_n (rst_n),
      .end_i (clean_end),
      .stat_i(stat_write),
      .val_i (stat_val),
      .open_o(lk_open)
   );

   pwb_busy #(.WR_CYCLES(WR_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .fire_i(fire),
      .busy_o(busy)
   );

   assign commit_ccr_o  = ccr_q;
   assign commit_base_o = base_q;
   assign commit_mask_o = mask_q;
   assign ptr_o         = col;
   assign busy_o        = busy;

   // R4: a commit follows a stop and carries at least one written column
   p_commit_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> ($past(stop_i) && !$past(busy) && commit_mask_o != '0));
   // R5: an aborted transfer never commits
   p_abort_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (live && abort_i) |=> !commit_o);
   // R6: control writes outside the status section need an open gate
   p_ccr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_o && commit_ccr_o && commit_base_o != STAT_BASE) |-> $past(lk_open));
   // R7: time section commits are always full
   p_rtc_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_o && commit_ccr_o && commit_base_o == RTC_B) |->
         (commit_mask_o[CCR_PG-1:0] == '1));
   // R8: commit and busy window begin together
   p_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> (busy || WR_CYCLES == 0));
endmodule

// File: tb/tb_page_wr_buf.sv
module tb_page_wr_buf;
   localparam int WR = 20;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0, tgt_ccr_i = 1'b0, byte_i = 1'b0;
   logic         stop_i = 1'b0, abort_i = 1'b0;
   logic [7:0]   start_addr_i = '0, byte_data_i = '0;
   logic         commit_o, commit_ccr_o, busy_o;
   logic [7:0]   commit_base_o;
   logic [15:0]  commit_mask_o;
   logic [127:0] commit_data_o;
   logic [3:0]   ptr_o;

   always #5 clk = ~clk;

   page_wr_buf dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_ccr_i(tgt_ccr_i),
      .start_addr_i(start_addr_i), .byte_i(byte_i), .byte_data_i(byte_data_i),
      .stop_i(stop_i), .abort_i(abort_i), .commit_o(commit_o),
      .commit_ccr_o(commit_ccr_o), .commit_base_o(commit_base_o),
      .commit_mask_o(commit_mask_o), .commit_data_o(commit_data_o),
      .ptr_o(ptr_o), .busy_o(busy_o)
   );

   typedef struct packed {
      logic         ccr;
      logic [7:0]   base;
      logic [15:0]  mask;
      logic [127:0] data;
   } item_t;

   item_t q[$];
   int total = 0;
   int bad = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every commit strobe
   always @(negedge clk) begin
      if (rst_n && commit_o) begin
         if (q.size() == 0) begin
            chk(1'b0, "R4", "unexpected commit base", 128'(commit_base_o), 128'hFFFF);
         end else begin
            item_t e;
            logic [127:0] got;
            e = q.pop_front();
            got = '0;
            for (int c = 0; c < 16; c++)
               if (e.mask[c]) got[8*c +: 8] = commit_data_o[8*c +: 8];
            chk(commit_ccr_o == e.ccr, "R4", "commit space", 128'(commit_ccr_o), 128'(e.ccr));
            chk(commit_base_o == e.base, "R4", "commit base", 128'(commit_base_o), 128'(e.base));
            chk(commit_mask_o == e.mask, "R4", "commit mask", 128'(commit_mask_o), 128'(e.mask));
            chk(got == e.data, "R3", "commit data", got, e.data);
         end
      end
   end

   // driver: one write transfer; pushes the expected commit when one is due
   task automatic wr_xfer(input bit ccr, input logic [7:0] addr, input int n,
                          input logic [7:0] seed, input bit exp_ok,
                          input string req, input bit poke = 1'b0);
      item_t e;
      int size, col, nb;
      logic [3:0] pk;
      size = ccr ? 8 : 16;
      col  = int'(addr) % size;
      e.ccr  = ccr;
      e.base = addr & ~8'(size - 1);
      e.mask = '0;
      e.data = '0;
      @(negedge clk);
      start_i = 1'b1; tgt_ccr_i = ccr; start_addr_i = addr;
      @(negedge clk);
      start_i = 1'b0;
      chk(ptr_o == 4'(col), "R1", "start column", 128'(ptr_o), 128'(col));
      for (int i = 0; i < n; i++) begin
         e.data[8*col +: 8] = seed + 8'(i);
         e.mask[col] = 1'b1;
         col = (col + 1) % size;
         byte_i = 1'b1; byte_data_i = seed + 8'(i);
         @(negedge clk);
         byte_i = 1'b0;
      end
      if (exp_ok) q.push_back(e);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk(ptr_o == 4'(col), req, "final column", 128'(ptr_o), 128'(col));
      if (exp_ok && poke) begin
         // R8: inputs during the busy window are ignored
         pk = ptr_o;
         start_i = 1'b1; tgt_ccr_i = 1'b0; start_addr_i = 8'h05;
         @(negedge clk);
         start_i = 1'b0; byte_i = 1'b1; byte_data_i = 8'hEE;
         @(negedge clk);
         byte_i = 1'b0; stop_i = 1'b1;
         @(negedge clk);
         stop_i = 1'b0;
         chk(ptr_o == pk, "R8", "pointer during busy", 128'(ptr_o), 128'(pk));
         while (busy_o) @(negedge clk);
      end else if (exp_ok) begin
         nb = 0;
         while (busy_o && nb < 1000) begin
            nb++;
            @(negedge clk);
         end
         chk(nb == WR, "R8", "busy length", 128'(nb), 128'(WR));
      end else begin
         chk(busy_o == 1'b0, req, "dropped transfer busy", 128'(busy_o), 128'(0));
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "WD", "watchdog expired", 128'(0), 128'(1));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk(commit_o == 1'b0, "R9", "commit in reset", 128'(commit_o), 128'(0));
      chk(busy_o == 1'b0, "R9", "busy in reset", 128'(busy_o), 128'(0));
      chk(ptr_o == 4'd0, "R9", "pointer in reset", 128'(ptr_o), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);

      wr_xfer(1'b0, 8'h2A, 12, 8'h40, 1'b1, "R2");   // wraps 10..15,0..5, ends at 6
      wr_xfer(1'b0, 8'h53, 18, 8'h80, 1'b1, "R3");   // overwrite of columns 3 and 4
      wr_xfer(1'b0, 8'h7F, 2, 8'h11, 1'b1, "R1");    // column 15 wraps to 0

      // R5: stop with no byte, then mid-byte abort
      wr_xfer(1'b0, 8'h20, 0, 8'h00, 1'b0, "R5");
      @(negedge clk);
      start_i = 1'b1; tgt_ccr_i = 1'b0; start_addr_i = 8'h64;
      @(negedge clk);
      start_i = 1'b0; byte_i = 1'b1; byte_data_i = 8'h33;
      @(negedge clk);
      byte_i = 1'b0; abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      @(negedge clk);
      chk(busy_o == 1'b0, "R5", "abort busy", 128'(busy_o), 128'(0));
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      repeat (2) @(negedge clk);
      chk(busy_o == 1'b0, "R5", "stray stop busy", 128'(busy_o), 128'(0));

      // R6: gate
      wr_xfer(1'b1, 8'h10, 1, 8'hAA, 1'b0, "R6");
      wr_xfer(1'b1, 8'h3F, 1, 8'h02, 1'b1, "R6");
      wr_xfer(1'b1, 8'h3F, 1, 8'h06, 1'b1, "R6");
      wr_xfer(1'b1, 8'h12, 3, 8'hA0, 1'b1, "R6");
      wr_xfer(1'b1, 8'h16, 4, 8'hB0, 1'b1, "R1");    // 6,7 then 0,1 in an 8-column section

      // R7: time section
      wr_xfer(1'b1, 8'h30, 3, 8'h50, 1'b0, "R7");
      wr_xfer(1'b1, 8'h34, 8, 8'h60, 1'b1, "R7");

      // R8: busy window ignores inputs
      wr_xfer(1'b0, 8'h00, 1, 8'h77, 1'b1, "R8", 1'b1);

      // R10: relock and broken key pair
      wr_xfer(1'b1, 8'h3F, 1, 8'h00, 1'b1, "R10");
      wr_xfer(1'b1, 8'h10, 1, 8'hC1, 1'b0, "R10");
      wr_xfer(1'b1, 8'h3F, 1, 8'h02, 1'b1, "R10");
      wr_xfer(1'b0, 8'h40, 1, 8'hC2, 1'b1, "R10");
      wr_xfer(1'b1, 8'h3F, 1, 8'h06, 1'b1, "R10");
      wr_xfer(1'b1, 8'h10, 1, 8'hC3, 1'b0, "R10");

      repeat (5) @(negedge clk);
      chk(q.size() == 0, "R4", "missing commits", 128'(q.size()), 128'(0));
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule